// File: doc/BRIEF.md
# ECC Protected SRAM Access Controller

This controller connects a 64-bit request/ready bus port to a single-port RAM whose lines each hold one 32-bit data word and 7 check bits. Every line is protected by a SECDED Hamming code whose syndrome also covers the word address of the access, including address bits above those the RAM decodes. The address is not stored, so a line reached through the wrong address fails its check. Reads are checked and corrected per 32-bit word. Full-word writes are encoded directly. A 64-bit write is issued as two back-to-back 32-bit line writes. Byte and halfword writes go through read, check, merge, re-encode and write back, so the check bits always match the line.

Single-bit (corrected) and multi-bit (uncorrectable) detections each produce their own one-cycle event pulse. The first detection after a clear is held in a capture register, with its type and word address, until a clear pulse. For test, an injection mask can be loaded. It is XORed into the check bits of the next line write only and then drops by itself.

A master raises `req` with `we`, `size`, `addr` and `wdata` and holds them until `ready` has been high for one cycle. `resp_err` is valid with `ready`. The size codes are 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. Bus byte lane n carries the byte whose address has `addr[2:0]` equal to n.

The control state machine has these states:
- `ST_IDLE`: goes to `ST_WR_A` on a word or doubleword write, to `ST_RMW_A` on a byte or halfword write, and to `ST_RD_A` on a read.
- `ST_WR_A`: goes to `ST_WR_B` for a doubleword, otherwise to `ST_RESP`.
- `ST_WR_B`: goes to `ST_RESP`.
- `ST_RD_A`: goes to `ST_RD_B`.
- `ST_RD_B`: goes to `ST_RD_C` for a doubleword, otherwise to `ST_RESP`.
- `ST_RD_C`: goes to `ST_RESP`.
- `ST_RMW_A`: goes to `ST_RMW_B`.
- `ST_RMW_B`: goes to `ST_RESP`. It writes back, or aborts the write back on an uncorrectable word.
- `ST_RESP`: goes to `ST_IDLE`.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: After reset `ready`, `resp_err`, `err_valid`, `ev_corr` and `ev_uncorr` are low, and no injection is armed.
- R2: A word write followed by a read of the same word returns it with `resp_err` low. A word or sub-word read returns the word in both 32-bit halves of `rdata`. A word access takes its data from bus bits 63:32 when `addr[2]` is 1 and from bits 31:0 otherwise.
- R3: A doubleword write stores bus bits 31:0 at the even word and bits 63:32 at the odd word, ignoring `addr[2]`. It uses two line writes, so `ready` comes 3 clock edges after `req` is accepted, against 2 edges for a word write.
- R4: A byte or halfword write replaces only the addressed lanes (halfword aligned on `addr[0]` = 0) and keeps the other bytes of the word. `ready` comes 3 edges after acceptance.
- R5: A word with one flipped bit reads back corrected, with `resp_err` low and one `ev_corr` pulse. `ev_corr` and `ev_uncorr` are never high together.
- R6: A loaded injection mask is XORed into the check bits of the next line write only. The line write after that is stored clean.
- R7: A word with a two-bit error gives `resp_err` high with `ready`, one `ev_uncorr` pulse, and the stored data bits uncorrected in `rdata`.
- R8: A byte or halfword write onto a word with an uncorrectable error is aborted with `resp_err` high, and the word is left unchanged.
- R9: Reading a line through an address that differs only in bits above the RAM's own address bits is reported as uncorrectable.
- R10: The first detection sets `err_valid` with `err_uncorr` (1 = uncorrectable) and `err_addr` (byte address shifted right by 2). Later detections leave these unchanged until cleared.
- R11: An `ev_clear` pulse with no detection in the same cycle drops `err_valid`.
- R12: In a doubleword read, a correctable half is fixed silently (`resp_err` low, `ev_corr` pulse). An uncorrectable half makes `resp_err` high.
- R13: A sub-word write onto a correctable word writes back the corrected, merged word, so a later read shows no error.
- R14: `ready` is high for exactly one cycle per request and never in the cycle `req` rises. A word read answers after 3 edges and a doubleword read after 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| addr | input | ADDR_W | Byte address |
| wdata | input | 64 | Write data, lane n = byte at addr[2:0] = n |
| ready | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Uncorrectable error on this access, valid with ready |
| rdata | output | 64 | Read data, valid with ready |
| inj_load | input | 1 | Load the injection mask |
| inj_mask | input | 7 | Check-bit mask for the next line write |
| ev_corr | output | 1 | Pulse: a corrected error was detected |
| ev_uncorr | output | 1 | Pulse: an uncorrectable error was detected |
| ev_clear | input | 1 | Clear the capture register |
| err_valid | output | 1 | Capture register holds an event |
| err_uncorr | output | 1 | Captured event type |
| err_addr | output | ADDR_W-2 | Captured word address |

## Verification
The handshake properties rely on a master that holds `req` and its fields steady from the rising edge until the cycle after `ready`. They also rely on the master not raising `req` in the cycle the controller answers. The bench drives every access through one task that raises `req` at a falling edge, drops it in the `ready` cycle, and waits one further edge before the next access. Injection loads and clear pulses are driven only while the controller is idle, so the capture properties never see a clear land on top of a detection. Reads target only lines that have been written, because unwritten lines carry no valid check bits for their address.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

    localparam int DATA_W  = 32;
    localparam int HAM_W   = 6;
    localparam int CHK_W   = HAM_W + 1;
    localparam int MAX_VEC = 57;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xfer_size_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_A,
        ST_WR_B,
        ST_RD_A,
        ST_RD_B,
        ST_RD_C,
        ST_RMW_A,
        ST_RMW_B,
        ST_RESP
    } ctrl_state_e;

    // Hamming bits: vector bit k sits at the k-th position (from 3 upward)
    // that is not a power of two.
    function automatic logic [HAM_W-1:0] ham_of(input logic [MAX_VEC-1:0] v);
        logic [HAM_W-1:0] h;
        int k;
        h = '0;
        k = 0;
        for (int q = 3; q < 64; q++) begin
            if ((q & (q - 1)) != 0) begin
                for (int i = 0; i < HAM_W; i++) begin
                    if (((q >> i) & 1) == 1) h[i] = h[i] ^ v[k];
                end
                k++;
            end
        end
        return h;
    endfunction

    // Vector index whose code position equals the syndrome, or -1.
    function automatic int locate(input logic [HAM_W-1:0] syn);
        int k;
        int hit;
        k = 0;
        hit = -1;
        for (int q = 3; q < 64; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (q == int'(syn)) hit = k;
                k++;
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/ecc_sram_enc.sv
module ecc_sram_enc
    import ecc_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [AW-1:0]     waddr,
    output logic [CHK_W-1:0]  chk
);
    localparam int VW = DATA_W + AW;

    if (VW > MAX_VEC) begin : g_too_wide
        $error("address too wide for 6 Hamming bits");
    end

    logic [MAX_VEC-1:0] vec;
    logic [HAM_W-1:0]   ham;

    always_comb begin
        vec = '0;
        vec[VW-1:0] = {waddr, data};
        ham = ham_of(vec);
        chk = {(^vec) ^ (^ham), ham};
    end

endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
    import ecc_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    input  logic [AW-1:0]     waddr,
    output logic [DATA_W-1:0] fixed,
    output logic              corr,
    output logic              uncorr
);
    localparam int VW = DATA_W + AW;

    logic [MAX_VEC-1:0] vec;
    logic [HAM_W-1:0]   syn;
    logic               par_err;
    int                 idx;

    always_comb begin
        vec = '0;
        vec[VW-1:0] = {waddr, data};
        syn     = ham_of(vec) ^ chk[HAM_W-1:0];
        par_err = (^vec) ^ (^chk);
        idx     = locate(syn);
        fixed   = data;
        corr    = 1'b0;
        uncorr  = 1'b0;
        if (par_err) begin
            if (syn == '0 || $onehot(syn)) begin
                corr = 1'b1;                      // a check bit flipped
            end else if (idx >= 0 && idx < DATA_W) begin
                fixed[idx[4:0]] = ~data[idx[4:0]];
                corr = 1'b1;
            end else begin
                uncorr = 1'b1;                    // address bit or out of range
            end
        end else if (syn != '0) begin
            uncorr = 1'b1;
        end
    end

endmodule

// File: rtl/ecc_sram_mem.sv
module ecc_sram_mem #(
    parameter int AW = 6,
    parameter int W  = 39
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] lines [DEPTH];

    always_ff @(posedge clk) begin
        if (we) lines[addr] <= wdata;
        rdata <= lines[addr];
    end

endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    output logic              ready,
    output logic              resp_err,
    output logic [63:0]       rdata,
    input  logic              inj_load,
    input  logic [6:0]        inj_mask,
    output logic              ev_corr,
    output logic              ev_uncorr,
    input  logic              ev_clear,
    output logic              err_valid,
    output logic              err_uncorr,
    output logic [ADDR_W-3:0] err_addr
);
    localparam int WA_W   = ADDR_W - 2;
    localparam int LINE_W = DATA_W + CHK_W;

    ctrl_state_e state, state_nx;

    logic              r_dword;
    logic [1:0]        r_size;
    logic [1:0]        r_boff;
    logic [WA_W-1:0]   r_waddr;
    logic [63:0]       r_wdata;
    logic [31:0]       rd_lo, rd_hi;
    logic              r_err;
    logic [CHK_W-1:0]  inj_q;
    logic              cap_valid, cap_uncorr;
    logic [WA_W-1:0]   cap_addr;

    logic              mem_we;
    logic [WA_W-1:0]   mem_waddr, dec_waddr;
    logic [31:0]       wr_word, merged, first_half;
    logic [CHK_W-1:0]  wr_chk;
    logic [LINE_W-1:0] mem_rd;
    logic [31:0]       dec_fixed;
    logic              dec_corr, dec_uncorr, dec_active;
    logic [3:0]        lane_en;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) begin
                if (!we)                                     state_nx = ST_RD_A;
                else if (size == SZ_WORD || size == SZ_DWORD) state_nx = ST_WR_A;
                else                                         state_nx = ST_RMW_A;
            end
            ST_WR_A:  state_nx = r_dword ? ST_WR_B : ST_RESP;
            ST_WR_B:  state_nx = ST_RESP;
            ST_RD_A:  state_nx = ST_RD_B;
            ST_RD_B:  state_nx = r_dword ? ST_RD_C : ST_RESP;
            ST_RD_C:  state_nx = ST_RESP;
            ST_RMW_A: state_nx = ST_RMW_B;
            ST_RMW_B: state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        mem_we     = 1'b0;
        mem_waddr  = r_waddr;
        dec_waddr  = r_waddr;
        wr_word    = first_half;
        dec_active = 1'b0;
        unique case (state)
            ST_WR_A:  mem_we = 1'b1;
            ST_WR_B: begin
                mem_we    = 1'b1;
                mem_waddr = r_waddr | WA_W'(1);
                wr_word   = r_wdata[63:32];
            end
            ST_RD_B: begin
                dec_active = 1'b1;
                if (r_dword) mem_waddr = r_waddr | WA_W'(1);
            end
            ST_RD_C: begin
                dec_active = 1'b1;
                dec_waddr  = r_waddr | WA_W'(1);
            end
            ST_RMW_B: begin
                dec_active = 1'b1;
                mem_we     = !dec_uncorr;
                wr_word    = merged;
            end
            default: ;
        endcase
    end

    assign ready     = (state == ST_RESP);
    assign resp_err  = ready & r_err;
    assign rdata     = {rd_hi, rd_lo};
    assign ev_corr   = dec_active & dec_corr;
    assign ev_uncorr = dec_active & dec_uncorr;
    assign err_valid  = cap_valid;
    assign err_uncorr = cap_uncorr;
    assign err_addr   = cap_addr;

    // ---------------- write data path ----------------
    assign first_half = r_waddr[0] ? r_wdata[63:32] : r_wdata[31:0];

    always_comb begin
        unique case (r_size)
            SZ_BYTE: lane_en = 4'b0001 << r_boff;
            SZ_HALF: lane_en = 4'b0011 << {r_boff[1], 1'b0};
            default: lane_en = 4'b1111;
        endcase
    end

    for (genvar b = 0; b < 4; b++) begin : g_merge
        assign merged[8*b +: 8] = lane_en[b] ? first_half[8*b +: 8] : dec_fixed[8*b +: 8];
    end

    ecc_sram_enc #(.AW(WA_W)) u_enc (
        .data  (wr_word),
        .waddr (mem_waddr),
        .chk   (wr_chk)
    );

    ecc_sram_mem #(.AW(MEM_AW), .W(LINE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_waddr[MEM_AW-1:0]),
        .wdata ({wr_chk ^ inj_q, wr_word}),
        .rdata (mem_rd)
    );

    ecc_sram_dec #(.AW(WA_W)) u_dec (
        .data   (mem_rd[DATA_W-1:0]),
        .chk    (mem_rd[LINE_W-1:DATA_W]),
        .waddr  (dec_waddr),
        .fixed  (dec_fixed),
        .corr   (dec_corr),
        .uncorr (dec_uncorr)
    );

    // ---------------- request and response registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_dword <= 1'b0;
            r_size  <= SZ_WORD;
            r_boff  <= '0;
            r_waddr <= '0;
            r_wdata <= '0;
            rd_lo   <= '0;
            rd_hi   <= '0;
            r_err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    r_dword <= (size == SZ_DWORD);
                    r_size  <= size;
                    r_boff  <= addr[1:0];
                    r_waddr <= (size == SZ_DWORD) ? {addr[ADDR_W-1:3], 1'b0} : addr[ADDR_W-1:2];
                    r_wdata <= wdata;
                    r_err   <= 1'b0;
                end
                ST_RD_B: begin
                    rd_lo <= dec_fixed;
                    if (!r_dword) rd_hi <= dec_fixed;
                    if (dec_uncorr) r_err <= 1'b1;
                end
                ST_RD_C: begin
                    rd_hi <= dec_fixed;
                    if (dec_uncorr) r_err <= 1'b1;
                end
                ST_RMW_B: if (dec_uncorr) r_err <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- injection mask: armed until the next line write ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        inj_q <= '0;
        else if (inj_load) inj_q <= inj_mask;
        else if (mem_we)   inj_q <= '0;
    end

    // ---------------- first-event capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid  <= 1'b0;
            cap_uncorr <= 1'b0;
            cap_addr   <= '0;
        end else if ((ev_corr || ev_uncorr) && (!cap_valid || ev_clear)) begin
            cap_valid  <= 1'b1;
            cap_uncorr <= ev_uncorr;
            cap_addr   <= dec_waddr;
        end else if (ev_clear) begin
            cap_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_sram_ctrl_chk.sv
module ecc_sram_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              resp_err,
    input logic              ev_corr,
    input logic              ev_uncorr,
    input logic              ev_clear,
    input logic              err_valid,
    input logic              err_uncorr,
    input logic [ADDR_W-3:0] err_addr
);
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R14

    AST_READY_NOT_ON_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !ready); // R14

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_corr && ev_uncorr)); // R5

    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> ready); // R7

    AST_CAPTURE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_corr || ev_uncorr) |=> err_valid); // R10

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !ev_clear) |=> (err_valid && $stable(err_addr) && $stable(err_uncorr))); // R10

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_clear && !ev_corr && !ev_uncorr) |=> !err_valid); // R11

endmodule

bind ecc_sram_ctrl ecc_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .ready      (ready),
    .resp_err   (resp_err),
    .ev_corr    (ev_corr),
    .ev_uncorr  (ev_uncorr),
    .ev_clear   (ev_clear),
    .err_valid  (err_valid),
    .err_uncorr (err_uncorr),
    .err_addr   (err_addr)
);

// File: tb/ecc_sram_ctrl_test.sv
`timescale 1ns/1ps
module ecc_sram_ctrl_test;

    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0, we = 1'b0;
    logic [1:0]        size = 2'd0;
    logic [ADDR_W-1:0] addr = '0;
    logic [63:0]       wdata = '0;
    logic              ready, resp_err;
    logic [63:0]       rdata;
    logic              inj_load = 1'b0;
    logic [6:0]        inj_mask = '0;
    logic              ev_corr, ev_uncorr;
    logic              ev_clear = 1'b0;
    logic              err_valid, err_uncorr;
    logic [ADDR_W-3:0] err_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int n_ce  = 0;
    int n_ue  = 0;

    always #5 clk = ~clk;

    ecc_sram_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(6)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
        .wdata(wdata), .ready(ready), .resp_err(resp_err), .rdata(rdata),
        .inj_load(inj_load), .inj_mask(inj_mask), .ev_corr(ev_corr),
        .ev_uncorr(ev_uncorr), .ev_clear(ev_clear), .err_valid(err_valid),
        .err_uncorr(err_uncorr), .err_addr(err_addr)
    );

    always @(negedge clk) begin
        if (ev_corr)   n_ce++;
        if (ev_uncorr) n_ue++;
    end

    typedef struct packed {
        logic        w;
        logic [1:0]  sz;
        logic [9:0]  a;
        logic [63:0] wd;
        logic [63:0] exp;
        logic        err;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b1, 2'd2, 10'h000, 64'h0000_0000_1122_3344, 64'h0, 1'b0, 4'd2}, // R2
        '{1'b1, 2'd2, 10'h004, 64'hAABB_CCDD_0000_0000, 64'h0, 1'b0, 4'd2}, // R2
        '{1'b0, 2'd3, 10'h000, 64'h0, 64'hAABB_CCDD_1122_3344, 1'b0, 4'd4}, // R14
        '{1'b1, 2'd3, 10'h008, 64'h0F0E_0D0C_0B0A_0908, 64'h0, 1'b0, 4'd3}, // R3
        '{1'b0, 2'd2, 10'h00C, 64'h0, 64'h0F0E_0D0C_0F0E_0D0C, 1'b0, 4'd3}, // R2
        '{1'b1, 2'd0, 10'h009, 64'h0000_0000_0000_7700, 64'h0, 1'b0, 4'd3}, // R4
        '{1'b0, 2'd2, 10'h008, 64'h0, 64'h0B0A_7708_0B0A_7708, 1'b0, 4'd3}, // R4
        '{1'b1, 2'd1, 10'h00E, 64'hBEEF_0000_0000_0000, 64'h0, 1'b0, 4'd3}, // R4
        '{1'b0, 2'd3, 10'h00C, 64'h0, 64'hBEEF_0D0C_0B0A_7708, 1'b0, 4'd4}, // R3
        '{1'b1, 2'd0, 10'h003, 64'h0000_0000_9900_0000, 64'h0, 1'b0, 4'd3}, // R4
        '{1'b0, 2'd1, 10'h000, 64'h0, 64'h9922_3344_9922_3344, 1'b0, 4'd3}, // R2
        '{1'b1, 2'd3, 10'h014, 64'h5566_7788_1234_ABCD, 64'h0, 1'b0, 4'd3}, // R3
        '{1'b0, 2'd2, 10'h010, 64'h0, 64'h1234_ABCD_1234_ABCD, 1'b0, 4'd3}  // R3
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [1:0] sz, input logic [9:0] a,
                        input logic [63:0] d, output logic [63:0] rd,
                        output logic er, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; size = sz; addr = a; wdata = d;
        lat = 0;
        do begin
            @(posedge clk); #1;
            lat++;
        end while (!ready && lat < 40);
        rd = rdata;
        er = resp_err;
        req = 1'b0;
        @(posedge clk);
    endtask

    task automatic inject(input logic [6:0] m);
        @(negedge clk); inj_load = 1'b1; inj_mask = m;
        @(negedge clk); inj_load = 1'b0; inj_mask = '0;
    endtask

    task automatic clear_events();
        @(negedge clk); ev_clear = 1'b1;
        @(negedge clk); ev_clear = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic        er;
        int          lat;
        int          ce0, ue0;

        repeat (3) @(posedge clk);
        #1;
        check("R1 ready after reset", {63'd0, ready}, 64'd0);
        check("R1 err_valid after reset", {63'd0, err_valid}, 64'd0);
        check("R1 event pulses after reset", {62'd0, ev_corr, ev_uncorr}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1: no armed injection out of reset, so the first write stores clean
        ce0 = n_ce; ue0 = n_ue;
        for (int i = 0; i < 13; i++) begin
            xfer(VECS[i].w, VECS[i].sz, VECS[i].a, VECS[i].wd, rd, er, lat);
            check($sformatf("R14 latency vec %0d", i), 64'(lat), 64'(VECS[i].lat));
            check($sformatf("R2 resp_err vec %0d", i), {63'd0, er}, {63'd0, VECS[i].err});
            if (!VECS[i].w) check($sformatf("R2 rdata vec %0d", i), rd, VECS[i].exp);
        end
        check("R1 no events on clean traffic", 64'(n_ce + n_ue), 64'(ce0 + ue0));

        // R5 / R6: single check-bit flip via injection
        inject(7'b000_0100);
        xfer(1'b1, 2'd2, 10'h020, 64'h0000_0000_CAFE_F00D, rd, er, lat);
        ce0 = n_ce;
        xfer(1'b0, 2'd2, 10'h020, 64'h0, rd, er, lat);
        check("R5 corrected data", rd, 64'hCAFE_F00D_CAFE_F00D);
        check("R5 no resp_err", {63'd0, er}, 64'd0);
        check("R5 one ev_corr pulse", 64'(n_ce - ce0), 64'd1);
        check("R10 capture type/addr", {54'd0, err_valid, err_uncorr, err_addr}, {54'd0, 1'b1, 1'b0, 8'h08});
        xfer(1'b1, 2'd2, 10'h024, 64'h1234_5678_0000_0000, rd, er, lat);
        ce0 = n_ce; ue0 = n_ue;
        xfer(1'b0, 2'd2, 10'h024, 64'h0, rd, er, lat);
        check("R6 mask self-cleared, data", rd, 64'h1234_5678_1234_5678);
        check("R6 mask self-cleared, no event", 64'(n_ce + n_ue), 64'(ce0 + ue0));

        clear_events();
        #1;
        check("R11 clear drops err_valid", {63'd0, err_valid}, 64'd0);

        // R7: two check bits flipped
        inject(7'b000_0011);
        xfer(1'b1, 2'd2, 10'h028, 64'h0000_0000_5555_AAAA, rd, er, lat);
        ue0 = n_ue;
        xfer(1'b0, 2'd2, 10'h028, 64'h0, rd, er, lat);
        check("R7 resp_err", {63'd0, er}, 64'd1);
        check("R7 raw data", rd, 64'h5555_AAAA_5555_AAAA);
        check("R7 one ev_uncorr pulse", 64'(n_ue - ue0), 64'd1);
        check("R10 capture uncorr", {54'd0, err_valid, err_uncorr, err_addr}, {54'd0, 1'b1, 1'b1, 8'h0A});

        // R8: sub-word write onto uncorrectable word is aborted
        xfer(1'b1, 2'd0, 10'h028, 64'h0000_0000_0000_0011, rd, er, lat);
        check("R8 abort resp_err", {63'd0, er}, 64'd1);
        xfer(1'b0, 2'd2, 10'h028, 64'h0, rd, er, lat);
        check("R8 word unchanged", rd, 64'h5555_AAAA_5555_AAAA);
        check("R8 still uncorrectable", {63'd0, er}, 64'd1);

        // R10: a later correctable error does not overwrite the capture
        inject(7'b100_0000);
        xfer(1'b1, 2'd2, 10'h030, 64'h0000_0000_0102_0304, rd, er, lat);
        xfer(1'b0, 2'd2, 10'h030, 64'h0, rd, er, lat);
        check("R10 capture held", {54'd0, err_valid, err_uncorr, err_addr}, {54'd0, 1'b1, 1'b1, 8'h0A});
        clear_events();

        // R13: read-modify-write scrubs a correctable word
        ce0 = n_ce;
        xfer(1'b1, 2'd0, 10'h030, 64'h0000_0000_0000_00FF, rd, er, lat);
        check("R13 rmw corrected event", 64'(n_ce - ce0), 64'd1);
        check("R13 rmw no resp_err", {63'd0, er}, 64'd0);
        ce0 = n_ce;
        xfer(1'b0, 2'd2, 10'h030, 64'h0, rd, er, lat);
        check("R13 scrubbed merged data", rd, 64'h0102_03FF_0102_03FF);
        check("R13 no event after scrub", 64'(n_ce - ce0), 64'd0);
        clear_events();

        // R12: doubleword reads with one bad half
        inject(7'b001_0000);
        xfer(1'b1, 2'd3, 10'h038, 64'h2222_2222_1111_1111, rd, er, lat);
        ce0 = n_ce;
        xfer(1'b0, 2'd3, 10'h038, 64'h0, rd, er, lat);
        check("R12 dword corrected data", rd, 64'h2222_2222_1111_1111);
        check("R12 dword corrected no err", {63'd0, er}, 64'd0);
        check("R12 dword ev_corr", 64'(n_ce - ce0), 64'd1);
        inject(7'b011_0000);
        xfer(1'b1, 2'd3, 10'h040, 64'h4444_4444_3333_3333, rd, er, lat);
        xfer(1'b0, 2'd3, 10'h040, 64'h0, rd, er, lat);
        check("R12 dword uncorrectable err", {63'd0, er}, 64'd1);
        check("R12 dword raw data", rd, 64'h4444_4444_3333_3333);
        clear_events();

        // R9: alias address above the array's decoded bits
        xfer(1'b1, 2'd2, 10'h050, 64'h0000_0000_600D_CAFE, rd, er, lat);
        ue0 = n_ue;
        xfer(1'b0, 2'd2, 10'h150, 64'h0, rd, er, lat);
        check("R9 alias read flagged", {63'd0, er}, 64'd1);
        check("R9 alias ev_uncorr", 64'(n_ue - ue0), 64'd1);
        check("R9 capture alias address", {54'd0, err_valid, err_uncorr, err_addr}, {54'd0, 1'b1, 1'b1, 8'h54});
        xfer(1'b0, 2'd2, 10'h050, 64'h0, rd, er, lat);
        check("R9 true address clean", rd, 64'h600D_CAFE_600D_CAFE);

        summary();
        $finish;
    end

endmodule